// File: doc/BRIEF.md
# Serial Audio Mode Control Slave

This block is the two-wire serial control port of a television stereo and second-audio-programme decoder. A host controller writes one control byte, and optionally a second test byte, through a standard I2C write. It reads back one status byte that reports whether the stereo pilot and the second-programme carrier are currently detected. SCL and SDA are oversampled by the much faster system clock. Each line passes through a two-flop synchronizer and a short stability filter. Start and stop conditions are recognised as SDA edges while SCL is high.

The stored control bits are combined with the two detector flags to form a routing matrix. The matrix drives a source select for each audio channel (off, L+R, the channel's own stereo signal, or the second programme) and a mute flag. It also drives a two-bit reception status. When the requested programme is not being received, the routing falls back to stereo or to mono. The remaining control bits are presented as individual configuration outputs for the analog sections.

Top module: `audio_mode_ctrl`

## Requirements
- R1: The slave responds to 7-bit address 1000000 (write byte 80h, read byte 81h) when `addr_strap` is low, and to 1000010 (84h/85h) when it is high. Any other address is not acknowledged, and the stored bytes are unchanged.
- R2: Bits travel MSB first and are sampled on SCL rising edges. After each 8-bit address or written byte that is accepted, the slave pulls SDA low during the 9th SCL clock. It only begins pulling while SCL is low.
- R3: After reset, the control byte and the test byte are zero. The routing outputs then show L+R on both channels, `mute` 0 and `mode_status` 00.
- R4: In a write transfer, the first data byte is stored as the control byte and the second as the test byte (`test_sel`). Any further bytes are acknowledged but stored nowhere. A one-byte write leaves the test byte unchanged.
- R5: A stop condition that arrives before all 8 bits of a data byte have been clocked in discards that byte. Both stored bytes keep their previous values.
- R6: A read returns one byte: bit 7 is the stereo-detected flag, bit 6 the SAP-detected flag, and bits 5..0 are 0. The master then gives the acknowledge slot. A not-acknowledge ends the read.
- R7: Control bits [1:0] pick the mode: 00 stereo, 01 SAP, 10 both, 11 mute. With 11, `mute` is 1 and both source selects are off (code 0), whatever the detectors report.
- R8: Control bit 2 (forced mono) set, with the mode not 11, puts L+R (code 1) on both channels.
- R9: With SAP detected and forced mono clear, mode 01 puts SAP (code 3) on both channels. Mode 10 puts L+R on the left channel and SAP on the right.
- R10: In every other unmuted case, both channels carry their own stereo signal (code 2) when stereo is detected, and L+R (code 1) when it is not.
- R11: `mode_status` is 00 for mono reception, 01 for SAP only, 10 for stereo only and 11 for stereo plus SAP.
- R12: A start condition that arrives in the middle of any transfer restarts address reception. A byte that was only partly received is dropped.
- R13: Control bits 3 through 7 appear on `sap_sens_hi` (bit 3), `st_sens_hi` (bit 4), `sap_gain_hi` (bit 5), `baseband_in` (bit 6) and `test_en` (bit 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain drive) |
| addr_strap | input | 1 | Picks the alternate slave address when high |
| stereo_det | input | 1 | Stereo pilot detected |
| sap_det | input | 1 | SAP carrier detected |
| left_src | output | 2 | Left source: 0 off, 1 L+R, 2 left, 3 SAP |
| right_src | output | 2 | Right source: 0 off, 1 L+R, 2 right, 3 SAP |
| mute | output | 1 | Both channels muted |
| mode_status | output | 2 | Reception status {stereo, SAP} |
| sap_sens_hi | output | 1 | High SAP detection sensitivity |
| st_sens_hi | output | 1 | High stereo detection sensitivity |
| sap_gain_hi | output | 1 | Higher SAP output level |
| baseband_in | output | 1 | Baseband rather than intercarrier input |
| test_en | output | 1 | Test mode requested (must stay 0 in use) |
| test_sel | output | 8 | Stored test byte |

## Verification
The commit of a written control byte and a change of a detector flag can reach the routing register in the same cycle. The routing must then reflect both new values together. The bench provokes this by raising the SAP flag timed to the eighth SCL rise of a mode-10 write, and it judges the settled L+R/SAP routing afterwards. The same pair is swept exhaustively at rest: every mode and forced-mono setting is combined with all four detector states. A restart arriving in the middle of a byte is also exercised, against a following complete write.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_WR       = 3'd3,
    ST_WR_ACK   = 3'd4,
    ST_RD       = 3'd5,
    ST_RD_ACK   = 3'd6
  } slv_state_t;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_MONO = 2'd1,
    SRC_OWN  = 2'd2,
    SRC_SAP  = 2'd3
  } src_t;

  localparam logic [1:0] SEL_STEREO = 2'b00;
  localparam logic [1:0] SEL_SAP    = 2'b01;
  localparam logic [1:0] SEL_BOTH   = 2'b10;
  localparam logic [1:0] SEL_MUTE   = 2'b11;

endpackage

// File: rtl/amc_sync_filter.sv
module amc_sync_filter #(
  parameter int             W        = 4,
  parameter int             FILT_LEN = 3,
  parameter logic [W-1:0]   RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_async,
  output logic [W-1:0] out_clean
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             clean_q, clean_n;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {2{RST_VAL[g]}};
      else        sync_q <= {sync_q[0], in_async[g]};
    end

    // output follows only after FILT_LEN stable cycles of a new level
    always_comb begin
      clean_n = clean_q;
      cnt_n   = '0;
      if (sync_q[1] != clean_q) begin
        if (cnt_q == CNT_LAST) clean_n = sync_q[1];
        else                   cnt_n   = cnt_q + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        clean_q <= RST_VAL[g];
      end else begin
        cnt_q   <= cnt_n;
        clean_q <= clean_n;
      end
    end

    assign out_clean[g] = clean_q;
  end

endmodule

// File: rtl/amc_i2c_slave.sv
module amc_i2c_slave
  import amc_pkg::*;
#(
  parameter logic [6:0] ADDR_LO = 7'h40,
  parameter logic [6:0] ADDR_HI = 7'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       addr_strap,
  input  logic       stereo_f,
  input  logic       sap_f,
  output logic       sda_pull,
  output logic [7:0] ctrl_q,
  output logic [7:0] test_q,
  output slv_state_t state_q,
  output logic [2:0] bit_cnt
);
  localparam logic [1:0] IDX_SAT = 2'd2;

  slv_state_t state_n;
  logic       scl_d, sda_d;
  logic [2:0] cnt_q, cnt_n;
  logic [6:0] shift_q, shift_n;
  logic [7:0] tx_q, tx_n;
  logic       ack_q, ack_n;
  logic       rw_q, rw_n;
  logic [1:0] idx_q, idx_n;
  logic [7:0] ctrl_n, test_n;
  logic [7:0] full;
  logic [6:0] own_addr;
  logic       rise, fall, start_c, stop_c;

  assign own_addr = addr_strap ? ADDR_HI : ADDR_LO;
  assign rise     = scl_f & ~scl_d;
  assign fall     = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
  assign full     = {shift_q, sda_f};

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    shift_n = shift_q;
    tx_n    = tx_q;
    ack_n   = ack_q;
    rw_n    = rw_q;
    idx_n   = idx_q;
    ctrl_n  = ctrl_q;
    test_n  = test_q;
    if (start_c) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      ack_n   = 1'b0;
    end else if (stop_c) begin
      state_n = ST_IDLE;
      ack_n   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: if (rise) begin
          shift_n = full[6:0];
          if (cnt_q == 3'd7) begin
            cnt_n = '0;
            if (full[7:1] == own_addr) begin
              state_n = ST_ADDR_ACK;
              rw_n    = full[0];
            end else begin
              state_n = ST_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 3'd1;
          end
        end
        ST_ADDR_ACK: if (fall) begin
          if (!ack_q) begin
            ack_n = 1'b1;
          end else begin
            ack_n = 1'b0;
            cnt_n = '0;
            idx_n = '0;
            if (rw_q) begin
              state_n = ST_RD;
              tx_n    = {stereo_f, sap_f, 6'b0};
            end else begin
              state_n = ST_WR;
            end
          end
        end
        ST_WR: if (rise) begin
          shift_n = full[6:0];
          if (cnt_q == 3'd7) begin
            cnt_n   = '0;
            state_n = ST_WR_ACK;
            if (idx_q == 2'd0)      ctrl_n = full;
            else if (idx_q == 2'd1) test_n = full;
            if (idx_q != IDX_SAT)   idx_n  = idx_q + 2'd1;
          end else begin
            cnt_n = cnt_q + 3'd1;
          end
        end
        ST_WR_ACK: if (fall) begin
          if (!ack_q) begin
            ack_n = 1'b1;
          end else begin
            ack_n   = 1'b0;
            state_n = ST_WR;
          end
        end
        ST_RD: if (fall) begin
          if (cnt_q == 3'd7) begin
            cnt_n   = '0;
            state_n = ST_RD_ACK;
          end else begin
            cnt_n = cnt_q + 3'd1;
            tx_n  = {tx_q[6:0], 1'b0};
          end
        end
        ST_RD_ACK: begin
          if (rise) shift_n = full[6:0];
          if (fall) begin
            if (shift_q[0]) begin
              state_n = ST_IDLE;
            end else begin
              state_n = ST_RD;
              tx_n    = {stereo_f, sap_f, 6'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      idx_q   <= '0;
      ctrl_q  <= '0;
      test_q  <= '0;
    end else begin
      state_q <= state_n;
      scl_d   <= scl_f;
      sda_d   <= sda_f;
      cnt_q   <= cnt_n;
      shift_q <= shift_n;
      tx_q    <= tx_n;
      ack_q   <= ack_n;
      rw_q    <= rw_n;
      idx_q   <= idx_n;
      ctrl_q  <= ctrl_n;
      test_q  <= test_n;
    end
  end

  assign sda_pull = ack_q | ((state_q == ST_RD) & ~tx_q[7]);
  assign bit_cnt  = cnt_q;

endmodule

// File: rtl/amc_route.sv
module amc_route
  import amc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ctrl_route,
  input  logic       stereo_f,
  input  logic       sap_f,
  output logic [1:0] left_src,
  output logic [1:0] right_src,
  output logic       mute,
  output logic [1:0] mode_status
);
  src_t       l_n, r_n, l_q, r_q;
  logic       mute_n, mute_q;
  logic [1:0] sel;
  logic       mono_force;

  assign sel        = ctrl_route[1:0];
  assign mono_force = ctrl_route[2];

  always_comb begin
    l_n    = SRC_MONO;
    r_n    = SRC_MONO;
    mute_n = 1'b0;
    if (sel == SEL_MUTE) begin
      l_n    = SRC_OFF;
      r_n    = SRC_OFF;
      mute_n = 1'b1;
    end else if (mono_force) begin
      l_n = SRC_MONO;
      r_n = SRC_MONO;
    end else if (sap_f && sel == SEL_SAP) begin
      l_n = SRC_SAP;
      r_n = SRC_SAP;
    end else if (sap_f && sel == SEL_BOTH) begin
      l_n = SRC_MONO;
      r_n = SRC_SAP;
    end else if (stereo_f) begin
      l_n = SRC_OWN;
      r_n = SRC_OWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q         <= SRC_MONO;
      r_q         <= SRC_MONO;
      mute_q      <= 1'b0;
      mode_status <= 2'b00;
    end else begin
      l_q         <= l_n;
      r_q         <= r_n;
      mute_q      <= mute_n;
      mode_status <= {stereo_f, sap_f};
    end
  end

  assign left_src  = l_q;
  assign right_src = r_q;
  assign mute      = mute_q;

endmodule

// File: rtl/audio_mode_ctrl.sv
module audio_mode_ctrl
  import amc_pkg::*;
#(
  parameter logic [6:0] ADDR_LO  = 7'h40,
  parameter logic [6:0] ADDR_HI  = 7'h42,
  parameter int         FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic       addr_strap,
  input  logic       stereo_det,
  input  logic       sap_det,
  output logic [1:0] left_src,
  output logic [1:0] right_src,
  output logic       mute,
  output logic [1:0] mode_status,
  output logic       sap_sens_hi,
  output logic       st_sens_hi,
  output logic       sap_gain_hi,
  output logic       baseband_in,
  output logic       test_en,
  output logic [7:0] test_sel
);
  logic [3:0] raw, clean;
  logic       scl_f, sda_f, stereo_f, sap_f;
  logic [7:0] ctrl_q, test_q;
  slv_state_t state_q;
  logic [2:0] bit_cnt;

  assign raw = {sap_det, stereo_det, sda_in, scl_in};

  amc_sync_filter #(.W(4), .FILT_LEN(FILT_LEN), .RST_VAL(4'b0011)) u_filt (
    .clk(clk), .rst_n(rst_n), .in_async(raw), .out_clean(clean)
  );

  assign scl_f    = clean[0];
  assign sda_f    = clean[1];
  assign stereo_f = clean[2];
  assign sap_f    = clean[3];

  amc_i2c_slave #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_slave (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .addr_strap(addr_strap), .stereo_f(stereo_f), .sap_f(sap_f),
    .sda_pull(sda_pull), .ctrl_q(ctrl_q), .test_q(test_q),
    .state_q(state_q), .bit_cnt(bit_cnt)
  );

  amc_route u_route (
    .clk(clk), .rst_n(rst_n), .ctrl_route(ctrl_q[2:0]),
    .stereo_f(stereo_f), .sap_f(sap_f),
    .left_src(left_src), .right_src(right_src),
    .mute(mute), .mode_status(mode_status)
  );

  assign sap_sens_hi = ctrl_q[3];
  assign st_sens_hi  = ctrl_q[4];
  assign sap_gain_hi = ctrl_q[5];
  assign baseband_in = ctrl_q[6];
  assign test_en     = ctrl_q[7];
  assign test_sel    = test_q;

endmodule

// File: rtl/amc_checker.sv
module amc_checker
  import amc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_pull,
  input logic [7:0] ctrl_q,
  input logic [7:0] test_q,
  input slv_state_t state_q,
  input logic [2:0] bit_cnt,
  input logic [1:0] left_src,
  input logic [1:0] right_src,
  input logic       mute
);

  assert_mute_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == SEL_MUTE) |=> (mute && left_src == 2'd0 && right_src == 2'd0));

  assert_force_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && ctrl_q[1:0] != SEL_MUTE) |=>
      (!mute && left_src == 2'd1 && right_src == 2'd1));

  assert_pull_on_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);

  assert_store_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctrl_q) || !$stable(test_q)) |-> ($past(scl_f) && !$past(scl_f, 2)));

  assert_read_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD && bit_cnt >= 3'd2) |-> sda_pull);

endmodule

bind audio_mode_ctrl amc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull(sda_pull),
  .ctrl_q(ctrl_q), .test_q(test_q), .state_q(state_q), .bit_cnt(bit_cnt),
  .left_src(left_src), .right_src(right_src), .mute(mute)
);

// File: tb/audio_mode_ctrl_bench.sv
module audio_mode_ctrl_bench;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_strap = 1'b0;
  logic stereo_det = 1'b0;
  logic sap_det = 1'b0;
  logic sda_pull, sda_line;
  logic [1:0] left_src, right_src, mode_status;
  logic mute, sap_sens_hi, st_sens_hi, sap_gain_hi, baseband_in, test_en;
  logic [7:0] test_sel;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  audio_mode_ctrl u_audio_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .addr_strap(addr_strap),
    .stereo_det(stereo_det), .sap_det(sap_det),
    .left_src(left_src), .right_src(right_src), .mute(mute),
    .mode_status(mode_status), .sap_sens_hi(sap_sens_hi),
    .st_sens_hi(st_sens_hi), .sap_gain_hi(sap_gain_hi),
    .baseband_in(baseband_in), .test_en(test_en), .test_sel(test_sel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic clk_bit(input bit b, output bit got);
    sda_m = b; half();
    scl_m = 1'b1; half();
    got = sda_line; half();
    scl_m = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit g;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], g);
    clk_bit(1'b1, g);
    ack = !g;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    bit g;
    for (int i = 7; i > 7 - n; i--) clk_bit(v[i], g);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit nack);
    bit g;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, g);
      v[i] = g;
    end
    clk_bit(nack, g);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, output bit aa, output bit ad);
    bus_start();
    send_byte(a, aa);
    send_byte(d, ad);
    bus_stop();
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  // expected {mute, left, right} from the routing requirements
  function automatic logic [4:0] exp_route(input logic [7:0] c, input bit st, input bit sp);
    logic [1:0] sel;
    sel = c[1:0];
    if (sel == 2'b11)                 return {1'b1, 2'd0, 2'd0};
    else if (c[2])                    return {1'b0, 2'd1, 2'd1};
    else if (sp && sel == 2'b01)      return {1'b0, 2'd3, 2'd3};
    else if (sp && sel == 2'b10)      return {1'b0, 2'd1, 2'd3};
    else if (st)                      return {1'b0, 2'd2, 2'd2};
    else                              return {1'b0, 2'd1, 2'd1};
  endfunction

  function automatic string route_tag(input logic [7:0] c, input bit sp);
    if (c[1:0] == 2'b11) return "R7";
    if (c[2]) return "R8";
    if (sp && c[1:0] != 2'b00) return "R9";
    return "R10";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit aa, ad;
    logic [7:0] rv;
    logic [4:0] e;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R3: reset state
    chk("R3", "left_src", left_src, 1);
    chk("R3", "right_src", right_src, 1);
    chk("R3", "mute", mute, 0);
    chk("R3", "mode_status", mode_status, 0);
    chk("R3", "test_sel", test_sel, 0);
    chk("R3", "fields", {test_en, baseband_in, sap_gain_hi, st_sens_hi, sap_sens_hi}, 0);

    // R7..R11 sweep of mode and forced mono against all detector states
    for (int c = 0; c < 8; c++) begin
      stereo_det = 1'b0; sap_det = 1'b0;
      wr1(8'h80, 8'(c), aa, ad);
      chk("R1", "addr ack 80h", aa, 1);
      chk("R2", "data ack", ad, 1);
      for (int d = 0; d < 4; d++) begin
        stereo_det = d[1]; sap_det = d[0];
        settle();
        e = exp_route(8'(c), d[1], d[0]);
        chk(route_tag(8'(c), d[0]), "mute", mute, e[4]);
        chk(route_tag(8'(c), d[0]), "left_src", left_src, e[3:2]);
        chk(route_tag(8'(c), d[0]), "right_src", right_src, e[1:0]);
        chk("R11", "mode_status", mode_status, d);
      end
    end
    stereo_det = 1'b0; sap_det = 1'b0;

    // R13 field positions
    for (int b = 3; b < 8; b++) begin
      wr1(8'h80, 8'(1 << b), aa, ad);
      settle();
      chk("R13", "fields", {test_en, baseband_in, sap_gain_hi, st_sens_hi, sap_sens_hi}, 1 << (b - 3));
    end

    // R4 multi-byte write
    bus_start();
    send_byte(8'h80, aa);
    send_byte(8'h01, ad); chk("R2", "byte1 ack", ad, 1);
    send_byte(8'h5A, ad); chk("R2", "byte2 ack", ad, 1);
    send_byte(8'h03, ad); chk("R4", "byte3 ack", ad, 1);
    bus_stop();
    settle();
    chk("R4", "test_sel", test_sel, 8'h5A);
    chk("R4", "third byte ignored mute", mute, 0);
    chk("R4", "control stored fields", {test_en, baseband_in, sap_gain_hi, st_sens_hi, sap_sens_hi}, 0);
    wr1(8'h80, 8'h00, aa, ad);
    settle();
    chk("R4", "one-byte write keeps test", test_sel, 8'h5A);

    // R5 stop mid-byte
    bus_start();
    send_byte(8'h80, aa);
    send_bits(8'hFF, 5);
    bus_stop();
    settle();
    chk("R5", "partial control mute", mute, 0);
    chk("R5", "partial control fields", {test_en, baseband_in, sap_gain_hi, st_sens_hi, sap_sens_hi}, 0);
    bus_start();
    send_byte(8'h80, aa);
    send_byte(8'h00, ad);
    send_bits(8'h00, 4);
    bus_stop();
    settle();
    chk("R5", "partial test byte", test_sel, 8'h5A);

    // R1 address matching and strap
    wr1(8'h82, 8'h03, aa, ad);
    settle();
    chk("R1", "foreign addr ack", aa, 0);
    chk("R1", "foreign addr mute", mute, 0);
    addr_strap = 1'b1;
    settle();
    wr1(8'h80, 8'h03, aa, ad);
    settle();
    chk("R1", "strap hi 80h ack", aa, 0);
    chk("R1", "strap hi 80h mute", mute, 0);
    wr1(8'h84, 8'h03, aa, ad);
    settle();
    chk("R1", "strap hi 84h ack", aa, 1);
    chk("R1", "strap hi 84h mute", mute, 1);
    wr1(8'h84, 8'h00, aa, ad);
    addr_strap = 1'b0;
    settle();

    // R6 reads
    for (int d = 0; d < 4; d++) begin
      stereo_det = d[1]; sap_det = d[0];
      settle();
      bus_start();
      send_byte(8'h81, aa);
      recv_byte(rv, 1'b1);
      bus_stop();
      chk("R6", "read addr ack", aa, 1);
      chk("R6", "read byte", rv, {d[1], d[0], 6'b0});
    end
    stereo_det = 1'b0; sap_det = 1'b0;
    settle();

    // R12 repeated start in address and in data
    bus_start();
    send_bits(8'h84, 4);
    bus_start();
    send_byte(8'h80, aa);
    send_byte(8'h03, ad);
    bus_stop();
    settle();
    chk("R12", "restart in address ack", aa, 1);
    chk("R12", "restart in address mute", mute, 1);
    bus_start();
    send_byte(8'h80, aa);
    send_bits(8'h00, 3);
    bus_start();
    send_byte(8'h80, aa);
    send_byte(8'h02, ad);
    bus_stop();
    settle();
    chk("R12", "restart in data mute", mute, 0);
    chk("R12", "restart in data left", left_src, 1);

    // commit and detector change in the same window
    wr1(8'h80, 8'h00, aa, ad);
    settle();
    fork
      wr1(8'h80, 8'h02, aa, ad);
      begin
        repeat (4 * Q + 36 * Q + 28 * Q + Q) @(negedge clk);
        sap_det = 1'b1;
      end
    join
    settle();
    chk("R9", "coincident left", left_src, 1);
    chk("R9", "coincident right", right_src, 3);
    chk("R11", "coincident status", mode_status, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule